// File: doc/BRIEF.md
# 100 Mb/s Transmit Code-Group Path

This block is the transmit half of a 100 Mb/s physical coding layer. It takes one 4-bit nibble at a time from the MAC side, together with a frame-enable and an error flag, and turns it into a 5-bit code group. The first two nibbles of every frame are replaced by a start delimiter pair. A two-group end delimiter is appended when the enable drops. Idle groups fill the line between frames. An error flag raised inside a frame swaps the current data group for an error group. A bypass input skips the translation: the error flag then serves as the fifth, most significant data bit, and the 5-bit word goes out unchanged.

Each group is shifted out most significant bit first, five bits per nibble slot. Every bit is XORed with the output of an 11-bit scrambler whose seed is an input, so that several instances produce uncorrelated line streams. The result is NRZI coded onto one output pin. The block runs from a single clock and advances one serial bit on each cycle where `bit_ce` is high. At 125 MHz with `bit_ce` tied high, this gives the 25 MHz nibble rate.

Top module: `phy100_tx_path`

## Requirements
- R1: While `rst_n` is low, and until the first `bit_ce` edge after the capture edge, `line_out` is 0 and `nib_slot` is 0.
- R2: Outside a frame, each slot with `tx_en` low transmits the idle group 11111. The first group after reset is idle.
- R3: A slot with `tx_en` high in the idle state transmits 11000. The next slot transmits 10001 whatever the inputs are. The nibbles sampled in those two slots are dropped.
- R4: Inside a frame, a slot with `tx_en` high and `tx_er` low transmits the nibble's standard data group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: Inside a frame, a slot with `tx_en` and `tx_er` both high transmits 00100 in place of the data group.
- R6: The first slot with `tx_en` low inside a frame transmits 01101. The next slot transmits 00111, and `tx_en` is ignored in that slot. Idle follows.
- R7: A slot with `bypass` high transmits {`tx_er`,`txd`} unchanged, with `tx_er` as bit 4, and returns the framing state to idle.
- R8: The scrambler is an 11-bit register s[10:0]. Each bit period it yields key s[10] and shifts left, taking in s[10]^s[8] (x^11+x^9+1). On the first clock edge after reset release it loads `seed`, or 0x2B5 when `seed` is 0. The register never holds zero.
- R9: A group is sent MSB first over five `bit_ce` edges. `nib_slot` is high during its fifth bit. Inputs are sampled only at an edge where `bit_ce` and `nib_slot` are both high, and input values at any other edge have no effect. With `bit_ce` low, nothing changes.
- R10: At each `bit_ce` edge, `line_out` toggles when (group bit XOR key) is 1 and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_ce | input | 1 | Serial bit advance enable |
| bypass | input | 1 | Send raw 5-bit words instead of translated groups |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Error flag, or data bit 4 in bypass |
| txd | input | 4 | Nibble data |
| seed | input | 11 | Scrambler start value |
| nib_slot | output | 1 | Last bit of the current group; inputs are sampled at the next enabled edge |
| line_out | output | 1 | NRZI-coded scrambled serial stream |

## Verification
A wrong framing state sends the wrong group in the very next slot. This is a delimiter, idle or data group in the wrong place, and once the line is descrambled it shows as a full 5-bit mismatch within five bit periods. A slip in the bit phase or the scrambler shifts every later bit, so `line_out` differs within one or two enabled edges and keeps differing. A wrong NRZI register inverts the line from that edge on. The bench therefore compares every enabled bit of `line_out`, and it also descrambles the line itself to name the group that went wrong.

// File: rtl/phy100_tx_pkg.sv
package phy100_tx_pkg;

  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  typedef logic [CG_W-1:0] cg_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;
  localparam cg_t CG_HALT = 5'b00100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_K    = 2'd1,
    ST_DATA = 2'd2,
    ST_R    = 2'd3
  } enc_st_e;

  function automatic cg_t map_4b5b(input logic [NIB_W-1:0] nib);
    cg_t g;
    case (nib)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/phy100_tx_enc.sv
module phy100_tx_enc
  import phy100_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             bypass,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output cg_t              cg_next,
  output enc_st_e          state
);

  enc_st_e st_q, st_d;
  cg_t     cg_d;

  // next group and framing state, consumed only when load is high
  always_comb begin
    st_d = st_q;
    cg_d = CG_IDLE;
    if (bypass) begin
      cg_d = {tx_er, txd};
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (tx_en) begin
            cg_d = CG_J;
            st_d = ST_K;
          end
        end
        ST_K: begin
          cg_d = CG_K;
          st_d = ST_DATA;
        end
        ST_DATA: begin
          if (!tx_en) begin
            cg_d = CG_T;
            st_d = ST_R;
          end else if (tx_er) begin
            cg_d = CG_HALT;
          end else begin
            cg_d = map_4b5b(txd);
          end
        end
        default: begin
          cg_d = CG_R;
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= ST_IDLE;
    else if (load) st_q <= st_d;
  end

  assign cg_next = cg_d;
  assign state   = st_q;

endmodule

// File: rtl/phy100_tx_scr.sv
module phy100_tx_scr #(
  parameter int             W        = 11,
  parameter int             TAP      = 9,
  parameter logic [W-1:0]   DEF_SEED = 'h2B5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_ld,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic         key,
  output logic [W-1:0] state
);

  logic [W-1:0] lf_q, lf_d, seed_eff;

  assign seed_eff = (seed == '0) ? DEF_SEED : seed;

  always_comb begin
    lf_d = lf_q;
    if (seed_ld)   lf_d = seed_eff;
    else if (step) lf_d = {lf_q[W-2:0], lf_q[W-1] ^ lf_q[TAP-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lf_q <= DEF_SEED;
    else        lf_q <= lf_d;
  end

  assign key   = lf_q[W-1];
  assign state = lf_q;

endmodule

// File: rtl/phy100_tx_ser.sv
module phy100_tx_ser
  import phy100_tx_pkg::*;
#(
  parameter int GW   = CG_W,
  localparam int PH_W = $clog2(GW),
  localparam logic [PH_W-1:0] LAST = PH_W'(GW - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [GW-1:0] cg_in,
  output logic          load,
  output logic          last_slot,
  output logic          msb,
  output logic [GW-1:0] shreg
);

  logic [PH_W-1:0] ph_q, ph_d;
  logic [GW-1:0]   sh_q, sh_d;

  assign last_slot = (ph_q == LAST);
  assign load      = adv && last_slot;

  always_comb begin
    ph_d = ph_q;
    sh_d = sh_q;
    if (load) begin
      ph_d = '0;
      sh_d = cg_in;
    end else if (adv) begin
      ph_d = ph_q + 1'b1;
      sh_d = {sh_q[GW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      sh_q <= '1;
    end else begin
      ph_q <= ph_d;
      sh_q <= sh_d;
    end
  end

  assign msb   = sh_q[GW-1];
  assign shreg = sh_q;

endmodule

// File: rtl/phy100_tx_path.sv
module phy100_tx_path
  import phy100_tx_pkg::*;
#(
  parameter int                  LFSR_W   = 11,
  parameter int                  LFSR_TAP = 9,
  parameter logic [LFSR_W-1:0]   DEF_SEED = 'h2B5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_ce,
  input  logic              bypass,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [NIB_W-1:0]  txd,
  input  logic [LFSR_W-1:0] seed,
  output logic              nib_slot,
  output logic              line_out
);

  logic              armed_q;
  logic              adv, load, msb, key;
  logic              nrzi_q, nrzi_d;
  cg_t               cg_next, shreg;
  enc_st_e           enc_state;
  logic [LFSR_W-1:0] lfsr_q;

  // first edge after reset captures the seed; the pipeline holds meanwhile
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= 1'b0;
  end

  assign adv = bit_ce && !armed_q;

  phy100_tx_enc u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .bypass  (bypass),
    .tx_en   (tx_en),
    .tx_er   (tx_er),
    .txd     (txd),
    .cg_next (cg_next),
    .state   (enc_state)
  );

  phy100_tx_ser #(.GW(CG_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .cg_in     (cg_next),
    .load      (load),
    .last_slot (nib_slot),
    .msb       (msb),
    .shreg     (shreg)
  );

  phy100_tx_scr #(.W(LFSR_W), .TAP(LFSR_TAP), .DEF_SEED(DEF_SEED)) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .seed_ld (armed_q),
    .step    (adv),
    .seed    (seed),
    .key     (key),
    .state   (lfsr_q)
  );

  always_comb begin
    nrzi_d = nrzi_q;
    if (adv) nrzi_d = nrzi_q ^ (msb ^ key);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nrzi_q <= 1'b0;
    else        nrzi_q <= nrzi_d;
  end

  assign line_out = nrzi_q;

endmodule

// File: rtl/phy100_tx_path_chk.sv
module phy100_tx_path_chk
  import phy100_tx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bit_ce,
  input logic        bypass,
  input logic        tx_en,
  input logic        tx_er,
  input logic [3:0]  txd,
  input logic        nib_slot,
  input logic        line_out,
  input logic [4:0]  shreg,
  input logic [1:0]  enc_state,
  input logic [10:0] lfsr_q
);

  logic take;
  assign take = bit_ce && nib_slot;

  assert_ce_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ce |=> ($stable(line_out) && $stable(nib_slot)));

  assert_slot_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !nib_slot);

  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 11'd0);

  assert_idle_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bypass && enc_state == ST_IDLE && !tx_en) |=> shreg == CG_IDLE);

  assert_start_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bypass && enc_state == ST_IDLE && tx_en) |=> shreg == CG_J);

  assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bypass && enc_state == ST_DATA && tx_en && tx_er) |=> shreg == CG_HALT);

  assert_end_t_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bypass && enc_state == ST_DATA && !tx_en) |=> shreg == CG_T);

  assert_raw_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bypass) |=> shreg == $past({tx_er, txd}));

endmodule

bind phy100_tx_path phy100_tx_path_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_ce    (bit_ce),
  .bypass    (bypass),
  .tx_en     (tx_en),
  .tx_er     (tx_er),
  .txd       (txd),
  .nib_slot  (nib_slot),
  .line_out  (line_out),
  .shreg     (shreg),
  .enc_state (enc_state),
  .lfsr_q    (lfsr_q)
);

// File: tb/phy100_tx_path_bench.sv
module phy100_tx_path_bench;

  localparam int          CLK_PERIOD = 8;
  localparam logic [10:0] DEF_SEED   = 11'h2B5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_ce = 1'b0, bypass = 1'b0, tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0]  txd = 4'h0;
  logic [10:0] seed = 11'h5A3;
  logic        nib_slot, line_out;

  int checks = 0;
  int fails  = 0;
  bit ce_mode = 0;

  // bench reference state
  int          m_phase;
  logic [4:0]  m_sreg;
  logic [10:0] m_lfsr;
  logic        m_nrzi;
  int          m_state;   // 0 idle, 1 K, 2 data, 3 R
  bit          m_armed;
  logic [4:0]  exp_q[$];
  string       tag_q[$];
  // line receiver
  bit          rx_pend;
  logic        rx_key, rx_prev;
  logic [4:0]  rx_sh;
  int          rx_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy100_tx_path u_phy100_tx_path (
    .clk(clk), .rst_n(rst_n), .bit_ce(bit_ce), .bypass(bypass),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .seed(seed),
    .nib_slot(nib_slot), .line_out(line_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] tbl(input logic [3:0] d);
    logic [4:0] t [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                           5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
    return t[d];
  endfunction

  task automatic expect_group(input logic en, er, byp, input logic [3:0] d);
    logic [4:0] g;
    string tag;
    if (byp) begin g = {er, d}; tag = "R7"; m_state = 0; end
    else case (m_state)
      0: if (en) begin g = 5'b11000; tag = "R3 J"; m_state = 1; end
         else begin g = 5'b11111; tag = "R2"; end
      1: begin g = 5'b10001; tag = "R3 K"; m_state = 2; end
      2: if (!en) begin g = 5'b01101; tag = "R6 T"; m_state = 3; end
         else if (er) begin g = 5'b00100; tag = "R5"; end
         else begin g = tbl(d); tag = "R4"; end
      default: begin g = 5'b00111; tag = "R6 R"; m_state = 0; end
    endcase
    m_sreg = g;
    exp_q.push_back(g);
    tag_q.push_back(tag);
  endtask

  task automatic model_edge();
    if (m_armed) begin
      m_lfsr  = (seed == 11'd0) ? DEF_SEED : seed;
      m_armed = 0;
    end else if (bit_ce) begin
      rx_pend = 1;
      rx_key  = m_lfsr[10];
      m_nrzi  = m_nrzi ^ (m_sreg[4] ^ m_lfsr[10]);
      m_lfsr  = {m_lfsr[9:0], m_lfsr[10] ^ m_lfsr[8]};
      if (m_phase == 4) begin
        m_phase = 0;
        expect_group(tx_en, tx_er, bypass, txd);
      end else begin
        m_phase++;
        m_sreg = {m_sreg[3:0], 1'b0};
      end
    end
  endtask

  task automatic check_outputs();
    chk(line_out == m_nrzi, "R10 line", line_out, m_nrzi);
    chk(nib_slot == (m_phase == 4), "R9 slot", nib_slot, (m_phase == 4));
    if (rx_pend) begin
      rx_pend = 0;
      rx_sh   = {rx_sh[3:0], (line_out ^ rx_prev) ^ rx_key};
      rx_cnt++;
      if (rx_cnt == 5) begin
        logic [4:0] e = exp_q.pop_front();
        string      t = tag_q.pop_front();
        rx_cnt = 0;
        chk(rx_sh == e, {t, " R8 group"}, rx_sh, e);
      end
    end
    rx_prev = line_out;
  endtask

  // called at a falling edge: drive, model the coming rising edge, check at next fall
  task automatic step(input logic ce, en, er, byp, input logic [3:0] d);
    bit_ce = ce; tx_en = en; tx_er = er; bypass = byp; txd = d;
    model_edge();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic nib(input logic en, er, byp, input logic [3:0] d);
    bit done = 0;
    while (!done) begin
      logic ce = ce_mode ? ($urandom % 4 != 0) : 1'b1;
      if (!m_armed && ce && m_phase == 4) begin
        step(ce, en, er, byp, d);
        done = 1;
      end else begin
        // values here fall outside a sample edge and must be ignored (R9)
        step(ce, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 4'($urandom));
      end
    end
  endtask

  task automatic frame(input int len, input int er_pct);
    for (int i = 0; i < len; i++)
      nib(1'b1, 1'($urandom % 100 < er_pct), 1'b0, 4'($urandom));
    nib(1'b0, 1'b0, 1'b0, 4'($urandom));
    nib(1'b1, 1'b1, 1'b0, 4'($urandom));   // R6: enable ignored in R slot
    nib(1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic do_reset(input logic [10:0] s);
    rst_n = 1'b0; seed = s; bit_ce = 1'b1; tx_en = 1'b1; txd = 4'hF;
    repeat (3) @(negedge clk);
    chk(line_out == 1'b0, "R1 line", line_out, 0);
    chk(nib_slot == 1'b0, "R1 slot", nib_slot, 0);
    m_phase = 0; m_sreg = 5'b11111; m_nrzi = 0; m_state = 0; m_armed = 1;
    m_lfsr = DEF_SEED;
    exp_q.delete(); tag_q.delete();
    exp_q.push_back(5'b11111); tag_q.push_back("R2 first");
    rx_pend = 0; rx_prev = 0; rx_cnt = 0; rx_sh = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset(11'h5A3);
    for (int i = 0; i < 3; i++) nib(1'b0, 1'b0, 1'b0, 4'h0);
    // R4: every data value in one frame
    nib(1'b1, 1'b0, 1'b0, 4'h5);
    nib(1'b1, 1'b0, 1'b0, 4'h5);
    for (int v = 0; v < 16; v++) nib(1'b1, 1'b0, 1'b0, 4'(v));
    nib(1'b0, 1'b0, 1'b0, 4'h0);
    nib(1'b0, 1'b0, 1'b0, 4'h0);
    // R5: error mid-frame
    for (int i = 0; i < 6; i++) nib(1'b1, 1'(i == 3), 1'b0, 4'hA);
    nib(1'b0, 1'b0, 1'b0, 4'h0);
    nib(1'b0, 1'b0, 1'b0, 4'h0);
    // one-nibble frame: J, K, T, R
    nib(1'b1, 1'b0, 1'b0, 4'h3);
    nib(1'b0, 1'b1, 1'b0, 4'h3);
    nib(1'b0, 1'b0, 1'b0, 4'h3);
    nib(1'b0, 1'b0, 1'b0, 4'h3);
    nib(1'b0, 1'b0, 1'b0, 4'h3);
    // R7: raw words, including all-ones and all-zero, and a bypass cut mid-frame
    nib(1'b0, 1'b1, 1'b1, 4'hF);
    nib(1'b0, 1'b0, 1'b1, 4'h0);
    nib(1'b1, 1'b1, 1'b1, 4'h4);
    nib(1'b1, 1'b0, 1'b0, 4'h1);
    nib(1'b1, 1'b0, 1'b0, 4'h1);
    nib(1'b1, 1'b0, 1'b1, 4'h9);
    nib(1'b0, 1'b0, 1'b0, 4'h0);
    // random frames with gapped bit enables (R9)
    ce_mode = 1;
    for (int f = 0; f < 30; f++) frame(1 + int'($urandom % 18), 10);
    // R8: zero seed falls back to the default
    ce_mode = 0;
    do_reset(11'd0);
    for (int f = 0; f < 4; f++) frame(2 + int'($urandom % 8), 20);
    // R8: another seed
    do_reset(11'h001);
    frame(6, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule